// File: doc/BRIEF.md
# PTP Packet Timestamp Capture Unit

This block latches the free-running 64-bit time value when a precision-time event packet starts, in the transmit and in the receive direction. Each direction has one capture slot. The slot holds its value until software reads the upper word, so every latched value belongs to exactly one packet. The block does not parse frames. The packet path supplies, with the start-of-packet strobe, a small set of metadata fields: ethertype, UDP flag and destination port, a header-version flag and the control/message-type byte.

Each direction's slot is a two-state machine. In `SLOT_IDLE` it waits for a capture. The transition ARM moves it to `SLOT_HELD` on an enabled, qualifying start-of-packet strobe and loads the time value sampled on that same clock edge. The transition RELEASE returns it from `SLOT_HELD` to `SLOT_IDLE` when the upper-word read strobe arrives. The transition DISARM forces `SLOT_IDLE` from either state whenever the direction's enable is low.

On receive there are two selection modes. In the version-2 event mode, a packet qualifies by ethertype or by UDP port. In the version-1 mode, a packet qualifies only over UDP and only for one programmed message type. A receive packet that is actually captured gets a one-cycle descriptor mark, so that the packet path can tag it.

Top module: `ts_capture_unit`

## Requirements
- R1: While reset is asserted and after it is released, both valid flags, the descriptor mark and all four timestamp words read zero.
- R2: When `tx_en`, `tx_sop` and `tx_event` are all high in a cycle with `tx_valid` low, the next cycle shows `tx_valid` high and `{tx_ts_hi,tx_ts_lo}` equal to the `time_now` of that cycle. Receive works the same way, with `rx_sop` and a qualifying packet.
- R3: While a direction's valid flag is high, further start-of-packet strobes in that direction capture nothing, and its timestamp words keep their value.
- R4: A high on a direction's upper-word read strobe (`tx_rd_hi` or `rx_rd_hi`) while that direction's valid flag is high clears the flag in the next cycle. A start-of-packet strobe in that same cycle is not captured.
- R5: While a direction's enable is low, its valid flag never sets. Dropping the enable clears a pending valid flag in the next cycle.
- R6: In version-2 mode (`rx_v1_mode`=0), a packet with `rx_hdr_v2`=1 and `rx_ethertype`=0x88F7 qualifies whatever its message byte, so path-delay messages (byte 0x02) are captured too.
- R7: In version-2 mode, a packet with `rx_hdr_v2`=1, `rx_is_udp`=1 and `rx_udp_dport`=319 qualifies. A UDP packet to any other port, or one with `rx_hdr_v2`=0, does not.
- R8: In version-1 mode (`rx_v1_mode`=1), a packet qualifies only if `rx_is_udp`=1, `rx_udp_dport`=319, `rx_hdr_v2`=0 and `rx_msg_byte` equals `rx_msg_sel` (0x00 Sync, 0x01 Delay_Req). A match on ethertype alone does not qualify.
- R9: `rx_desc_ts` is high for exactly the one cycle after an `rx_sop` that was captured, and it stays low for packets that were not captured.
- R10: The low word is bits 31:0 of the captured time and the high word is bits 63:32, including values where the low word has just wrapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Free-running time value |
| tx_en | input | 1 | Transmit capture enable |
| tx_sop | input | 1 | Transmit start-of-packet strobe |
| tx_event | input | 1 | Transmit packet is marked for timestamping |
| tx_rd_hi | input | 1 | Transmit upper-word read strobe (release) |
| rx_en | input | 1 | Receive capture enable |
| rx_v1_mode | input | 1 | 0: version-2 events, 1: version-1 message match |
| rx_msg_sel | input | 8 | Programmed version-1 message type |
| rx_sop | input | 1 | Receive start-of-packet strobe |
| rx_ethertype | input | 16 | Packet ethertype |
| rx_is_udp | input | 1 | Packet is UDP |
| rx_udp_dport | input | 16 | UDP destination port |
| rx_hdr_v2 | input | 1 | Packet carries a version-2 header |
| rx_msg_byte | input | 8 | Control/message-type byte |
| rx_rd_hi | input | 1 | Receive upper-word read strobe (release) |
| tx_ts_lo | output | 32 | Transmit timestamp, low word |
| tx_ts_hi | output | 32 | Transmit timestamp, high word |
| tx_valid | output | 1 | Transmit slot holds a timestamp |
| rx_ts_lo | output | 32 | Receive timestamp, low word |
| rx_ts_hi | output | 32 | Receive timestamp, high word |
| rx_valid | output | 1 | Receive slot holds a timestamp |
| rx_desc_ts | output | 1 | Descriptor mark for the captured receive packet |

## Verification
The receive path is driven with these patterns:
- layer-2 packets carrying several message bytes, including path-delay;
- UDP packets to port 319 and to a neighbouring port;
- packets with both header versions;
- ethertype-only packets while in version-1 mode.

Taken together, these separate the ethertype path, the port path, the version gate and the message compare.

Strobes arrive while a slot is held, in the same cycle as a read, and while the enable is low. These patterns separate the lock from the release order and from the disarm path.

The time source is started just below a low-word wrap, so the word split is checked where a carry crosses the two words.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_state_e;

    typedef enum logic {
        RXM_V2_EVENT = 1'b0,
        RXM_V1_MSG   = 1'b1
    } rx_mode_e;
endpackage

// File: rtl/ts_rx_qualifier.sv
module ts_rx_qualifier #(
    parameter int          ETYPE_W    = 16,
    parameter int          PORT_W     = 16,
    parameter int          MSG_W      = 8,
    parameter logic [15:0] PTP_ETYPE  = 16'h88F7,
    parameter logic [15:0] EVENT_PORT = 16'd319
) (
    input  logic               v1_mode,
    input  logic [MSG_W-1:0]   msg_sel,
    input  logic [ETYPE_W-1:0] ethertype,
    input  logic               is_udp,
    input  logic [PORT_W-1:0]  udp_dport,
    input  logic               hdr_v2,
    input  logic [MSG_W-1:0]   msg_byte,
    output logic               qualifies
);
    import ts_cap_pkg::*;

    logic l2_hit;
    logic l4_hit;
    logic msg_hit;

    assign l2_hit  = (ethertype == ETYPE_W'(PTP_ETYPE));
    assign l4_hit  = is_udp && (udp_dport == PORT_W'(EVENT_PORT));
    assign msg_hit = (msg_byte == msg_sel);

    always_comb begin
        unique case (rx_mode_e'(v1_mode))
            RXM_V2_EVENT: qualifies = hdr_v2 && (l2_hit || l4_hit);
            RXM_V1_MSG:   qualifies = !hdr_v2 && l4_hit && msg_hit;
            default:      qualifies = 1'b0;
        endcase
    end
endmodule

// File: rtl/ts_slot.sv
module ts_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sop,
    input  logic              qual,
    input  logic              rd_hi,
    input  logic [TIME_W-1:0] time_now,
    output logic [TIME_W-1:0] ts_q,
    output logic              held,
    output logic              arm
);
    import ts_cap_pkg::*;

    slot_state_e state_q;
    slot_state_e state_d;

    always_comb begin
        state_d = state_q;
        arm     = 1'b0;
        unique case (state_q)
            SLOT_IDLE: begin
                if (en && sop && qual) begin
                    state_d = SLOT_HELD;
                    arm     = 1'b1;
                end
            end
            SLOT_HELD: begin
                if (rd_hi) state_d = SLOT_IDLE;
            end
            default: state_d = SLOT_IDLE;
        endcase
        if (!en) begin
            state_d = SLOT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   ts_q <= '0;
        else if (arm) ts_q <= time_now;
    end

    assign held = (state_q == SLOT_HELD);
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit #(
    parameter int          TIME_W     = 64,
    parameter int          WORD_W     = 32,
    parameter int          ETYPE_W    = 16,
    parameter int          PORT_W     = 16,
    parameter int          MSG_W      = 8,
    parameter logic [15:0] PTP_ETYPE  = 16'h88F7,
    parameter logic [15:0] EVENT_PORT = 16'd319
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TIME_W-1:0]        time_now,
    input  logic                     tx_en,
    input  logic                     tx_sop,
    input  logic                     tx_event,
    input  logic                     tx_rd_hi,
    input  logic                     rx_en,
    input  logic                     rx_v1_mode,
    input  logic [MSG_W-1:0]         rx_msg_sel,
    input  logic                     rx_sop,
    input  logic [ETYPE_W-1:0]       rx_ethertype,
    input  logic                     rx_is_udp,
    input  logic [PORT_W-1:0]        rx_udp_dport,
    input  logic                     rx_hdr_v2,
    input  logic [MSG_W-1:0]         rx_msg_byte,
    input  logic                     rx_rd_hi,
    output logic [WORD_W-1:0]        tx_ts_lo,
    output logic [TIME_W-WORD_W-1:0] tx_ts_hi,
    output logic                     tx_valid,
    output logic [WORD_W-1:0]        rx_ts_lo,
    output logic [TIME_W-WORD_W-1:0] rx_ts_hi,
    output logic                     rx_valid,
    output logic                     rx_desc_ts
);
    localparam int HI_W = TIME_W - WORD_W;

    logic              rx_qual;
    logic              tx_arm;
    logic              rx_arm;
    logic [TIME_W-1:0] tx_ts;
    logic [TIME_W-1:0] rx_ts;

    ts_rx_qualifier #(
        .ETYPE_W(ETYPE_W), .PORT_W(PORT_W), .MSG_W(MSG_W),
        .PTP_ETYPE(PTP_ETYPE), .EVENT_PORT(EVENT_PORT)
    ) u_qual (
        .v1_mode  (rx_v1_mode),
        .msg_sel  (rx_msg_sel),
        .ethertype(rx_ethertype),
        .is_udp   (rx_is_udp),
        .udp_dport(rx_udp_dport),
        .hdr_v2   (rx_hdr_v2),
        .msg_byte (rx_msg_byte),
        .qualifies(rx_qual)
    );

    ts_slot #(.TIME_W(TIME_W)) u_tx_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (tx_en),
        .sop     (tx_sop),
        .qual    (tx_event),
        .rd_hi   (tx_rd_hi),
        .time_now(time_now),
        .ts_q    (tx_ts),
        .held    (tx_valid),
        .arm     (tx_arm)
    );

    ts_slot #(.TIME_W(TIME_W)) u_rx_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (rx_en),
        .sop     (rx_sop),
        .qual    (rx_qual),
        .rd_hi   (rx_rd_hi),
        .time_now(time_now),
        .ts_q    (rx_ts),
        .held    (rx_valid),
        .arm     (rx_arm)
    );

    // One-cycle mark for the packet whose start won the receive slot.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_desc_ts <= 1'b0;
        else        rx_desc_ts <= rx_arm;
    end

    // The transmit slot needs no per-packet mark; its arm pulse is folded
    // into a no-op so that every slot pin stays connected.
    logic tx_arm_unused;
    assign tx_arm_unused = tx_arm;

    assign tx_ts_lo = tx_ts[WORD_W-1:0];
    assign tx_ts_hi = tx_ts[TIME_W-1:WORD_W];
    assign rx_ts_lo = rx_ts[WORD_W-1:0];
    assign rx_ts_hi = rx_ts[TIME_W-1:WORD_W];

    initial begin
        if (HI_W <= 0) $error("TIME_W must exceed WORD_W");
    end
endmodule

// File: rtl/ts_capture_checker.sv
module ts_capture_checker #(
    parameter int TIME_W = 64,
    parameter int WORD_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [TIME_W-1:0]        time_now,
    input logic                     tx_en,
    input logic                     tx_rd_hi,
    input logic                     tx_valid,
    input logic [WORD_W-1:0]        tx_ts_lo,
    input logic [TIME_W-WORD_W-1:0] tx_ts_hi,
    input logic                     rx_en,
    input logic                     rx_rd_hi,
    input logic                     rx_sop,
    input logic                     rx_valid,
    input logic [WORD_W-1:0]        rx_ts_lo,
    input logic [TIME_W-WORD_W-1:0] rx_ts_hi,
    input logic                     rx_desc_ts
);
    p_tx_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> ({tx_ts_hi, tx_ts_lo} == $past(time_now)));

    p_rx_time_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> ({rx_ts_hi, rx_ts_lo} == $past(time_now)));

    p_tx_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_en && !tx_rd_hi) |=>
            (tx_valid && $stable(tx_ts_lo) && $stable(tx_ts_hi)));

    p_rx_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_en && !rx_rd_hi) |=>
            (rx_valid && $stable(rx_ts_lo) && $stable(rx_ts_hi)));

    p_tx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_rd_hi) |=> !tx_valid);

    p_rx_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_rd_hi) |=> !rx_valid);

    p_tx_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !tx_valid);

    p_rx_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_valid);

    p_desc_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_desc_ts |-> ($rose(rx_valid) && $past(rx_sop)));
endmodule

bind ts_capture_unit ts_capture_checker #(.TIME_W(TIME_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/ts_capture_unit_test.sv
`timescale 1ns/1ps
module ts_capture_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = 64'h0123_4567_FFFF_FFF0;
    logic        tx_en = 0, tx_sop = 0, tx_event = 0, tx_rd_hi = 0;
    logic        rx_en = 0, rx_v1_mode = 0, rx_sop = 0, rx_is_udp = 0;
    logic        rx_hdr_v2 = 0, rx_rd_hi = 0;
    logic [7:0]  rx_msg_sel = 8'h00, rx_msg_byte = 8'h00;
    logic [15:0] rx_ethertype = 16'h0800, rx_udp_dport = 16'd0;
    logic [31:0] tx_ts_lo, tx_ts_hi, rx_ts_lo, rx_ts_hi;
    logic        tx_valid, rx_valid, rx_desc_ts;

    ts_capture_unit uut (.*);

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string phase = "R1";

    // Behavioural reference state
    bit          m_tx_v = 0, m_rx_v = 0, m_desc = 0;
    logic [63:0] m_tx_t = 0, m_rx_t = 0;

    function automatic bit rx_ok();
        if (!rx_v1_mode)
            return rx_hdr_v2 && (rx_ethertype == 16'h88F7 ||
                                 (rx_is_udp && rx_udp_dport == 16'd319));
        return !rx_hdr_v2 && rx_is_udp && rx_udp_dport == 16'd319 &&
               rx_msg_byte == rx_msg_sel;
    endfunction

    task automatic model_edge();
        bit tc, rc;
        if (!rst_n) begin
            m_tx_v = 0; m_rx_v = 0; m_desc = 0; m_tx_t = 0; m_rx_t = 0;
            return;
        end
        tc = tx_en && tx_sop && tx_event && !m_tx_v;
        rc = rx_en && rx_sop && rx_ok() && !m_rx_v;
        if (tc) m_tx_t = time_now;
        if (rc) m_rx_t = time_now;
        if (!tx_en) m_tx_v = 0; else if (tc) m_tx_v = 1; else if (tx_rd_hi) m_tx_v = 0;
        if (!rx_en) m_rx_v = 0; else if (rc) m_rx_v = 1; else if (rx_rd_hi) m_rx_v = 0;
        m_desc = rc;
    endtask

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("tx_valid", 64'(tx_valid), 64'(m_tx_v));
        chk("tx_ts", {tx_ts_hi, tx_ts_lo}, m_tx_t);
        chk("rx_valid", 64'(rx_valid), 64'(m_rx_v));
        chk("rx_ts", {rx_ts_hi, rx_ts_lo}, m_rx_t);
        chk("rx_desc_ts", 64'(rx_desc_ts), 64'(m_desc));
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        time_now = time_now + 64'h0000_0000_0000_0007;
    endtask

    task automatic tx_pkt(bit ev);
        tx_sop = 1; tx_event = ev; step(); tx_sop = 0; tx_event = 0; step();
    endtask

    task automatic rx_pkt(logic [15:0] et, bit udp, logic [15:0] port, bit v2, logic [7:0] msg);
        rx_ethertype = et; rx_is_udp = udp; rx_udp_dport = port;
        rx_hdr_v2 = v2; rx_msg_byte = msg; rx_sop = 1;
        step();
        rx_sop = 0; step();
    endtask

    task automatic rd_tx(); tx_rd_hi = 1; step(); tx_rd_hi = 0; step(); endtask
    task automatic rd_rx(); rx_rd_hi = 1; step(); rx_rd_hi = 0; step(); endtask

    initial begin
        @(negedge clk);
        phase = "R1";
        repeat (3) step();
        rst_n = 1; step(); step();

        tx_en = 1; rx_en = 1;
        phase = "R2";   tx_pkt(1); tx_pkt(0);
        phase = "R10";  step();
        phase = "R3";   tx_pkt(1); tx_pkt(1);
        phase = "R4";
        tx_rd_hi = 1; tx_sop = 1; tx_event = 1; step();
        tx_rd_hi = 0; tx_sop = 0; tx_event = 0; step();
        tx_pkt(1); rd_tx(); rd_tx();
        phase = "R5";
        tx_pkt(1); tx_en = 0; step(); tx_pkt(1); step(); tx_en = 1; step();
        phase = "R2";   tx_pkt(1);

        phase = "R6";
        rx_pkt(16'h88F7, 0, 0, 1, 8'h02); rd_rx();
        rx_pkt(16'h88F7, 0, 0, 1, 8'h00); rd_rx();
        rx_pkt(16'h88F7, 0, 0, 0, 8'h00);
        phase = "R7";
        rx_pkt(16'h0800, 1, 16'd319, 1, 8'h01);
        phase = "R9";   rx_pkt(16'h0800, 1, 16'd319, 1, 8'h01); rd_rx();
        phase = "R7";
        rx_pkt(16'h0800, 1, 16'd320, 1, 8'h00);
        rx_pkt(16'h0800, 0, 16'd319, 1, 8'h00);
        rx_pkt(16'h0800, 1, 16'd319, 0, 8'h00);
        rx_pkt(16'h0800, 1, 16'd319, 1, 8'h09); rd_rx();

        phase = "R8";
        rx_v1_mode = 1; rx_msg_sel = 8'h00;
        rx_pkt(16'h0800, 1, 16'd319, 0, 8'h01);
        rx_pkt(16'h88F7, 0, 0, 0, 8'h00);
        rx_pkt(16'h88F7, 0, 0, 1, 8'h00);
        rx_pkt(16'h0800, 1, 16'd319, 1, 8'h00);
        rx_pkt(16'h0800, 1, 16'd319, 0, 8'h00); rd_rx();
        rx_msg_sel = 8'h01;
        rx_pkt(16'h0800, 1, 16'd319, 0, 8'h00);
        rx_pkt(16'h0800, 1, 16'd319, 0, 8'h01);
        phase = "R5";
        rx_en = 0; step(); rx_pkt(16'h0800, 1, 16'd319, 0, 8'h01);
        rx_en = 1; step();
        phase = "R9";   rx_pkt(16'h0800, 1, 16'd319, 0, 8'h01); step();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule